// File: doc/BRIEF.md
# Bidirectional I/O Port with Pin-Change Interrupt

This block is an 8-bit general-purpose I/O port. Each pin has its own direction bit: a pin set as an input leaves its driver off, a pin set as an output drives the value held in the output latch. Reads of the port return the pin levels after a two-stage synchronizer, not the latch contents. The single-bit set and clear operations are read-modify-write operations. They take the synchronized pin byte, change one bit and load the whole byte into the output latch. A shared active-low enable turns on the weak pull-ups. Pull-ups apply only to pins that are inputs.

The upper half of the port (pins 7 to 4) watches for changes. Each access to the port (read, write, or bit operation) captures those pins into a snapshot. On every cycle, any upper pin that is an input and differs from its snapshot sets the change flag. While the difference persists the flag is set again on every cycle, so software must access the port to end the mismatch before the clear strobe can take effect.

All register accesses are single-cycle strobes with no back-pressure: the port accepts every strobe on the edge where it is high, and the read value is valid in the same cycle as the read strobe. Pad electronics and any edge-triggered interrupt on bit 0 sit outside this block.

Top module: `gpio_chg_port`

## Requirements
- R1: While reset is asserted, all pins are inputs (pad_oe = 0x00), the output latch is 0x00 (pad_out = 0x00), pad_pu = 0x00 and chg_flag = 0.
- R2: A dir_wr strobe loads wr_data into the direction register at that edge. A direction bit of 1 means input, so pad_oe[i] is the inverse of direction bit i.
- R3: A dat_wr strobe loads wr_data into the output latch at that edge, and pad_out shows the latch whatever the direction.
- R4: With rd_dir = 0, rd_data returns the pin levels through a two-flop synchronizer, so rd_data shows the pad_in value that was present two rising edges earlier.
- R5: With rd_dir = 1, rd_data returns the direction register.
- R6: A bit_set or bit_clr strobe with index bit_idx loads the output latch with the synchronized pin byte, with bit bit_idx forced to 1 (set) or to 0 (clear). When both are high, the clear wins. A dat_wr in the same cycle takes priority over either one.
- R7: pu_en_n (active low) is registered once, with a reset value of disabled. pad_pu[i] is high only when that registered enable is on and pin i is an input.
- R8: When any pin among 7:4 that is an input has a synchronized level different from its snapshot, chg_flag is 1 after the next edge.
- R9: Pins 3:0, and pins among 7:4 that are outputs, never set chg_flag, whatever their levels and snapshot values.
- R10: The snapshot of pins 7:4 is loaded from the synchronized pins at every dat_rd, dat_wr, bit_set or bit_clr edge. After that edge, pins that stay steady no longer mismatch.
- R11: chg_clr clears chg_flag at the next edge only when there is no mismatch in that cycle. A mismatch wins over the clear. Without chg_clr and without a mismatch, the flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, one instruction cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 8 | Write data for latch and direction writes |
| dat_wr | input | 1 | Output latch write strobe |
| dir_wr | input | 1 | Direction register write strobe |
| bit_set | input | 1 | Read-modify-write set of one bit |
| bit_clr | input | 1 | Read-modify-write clear of one bit |
| bit_idx | input | 3 | Bit index for set and clear |
| dat_rd | input | 1 | Port read strobe (captures the snapshot) |
| rd_dir | input | 1 | Read select: 1 selects the direction register |
| rd_data | output | 8 | Read data, combinational |
| pu_en_n | input | 1 | Active-low weak pull-up enable |
| pad_in | input | 8 | Pin input levels |
| pad_out | output | 8 | Output latch toward the pads |
| pad_oe | output | 8 | Per-pin driver enable |
| pad_pu | output | 8 | Per-pin weak pull-up enable |
| chg_flag | output | 1 | Change interrupt flag |
| chg_clr | input | 1 | Change flag clear strobe |

## Verification
The bench builds the port with its default parameters: eight pins, change detection on the upper four, and two synchronizer stages. The reference model holds the synchronizer as a queue as deep as the stage count. Because the pins are free-running bench inputs, a bit operation on an output pin can pick up a pin level that differs from the latch, which exercises the read-modify-write hazard directly. A long pseudo-random phase mixes direction changes with port accesses and clear strobes, so the flag is checked both while mismatches persist and after an access has ended them.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    BITOP_NONE = 2'd0,
    BITOP_SET  = 2'd1,
    BITOP_CLR  = 2'd2
  } bitop_e;

  function automatic bitop_e decode_bitop(input logic set_i, input logic clr_i);
    if (clr_i)      return BITOP_CLR;
    else if (set_i) return BITOP_SET;
    else            return BITOP_NONE;
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     wr_data,
  input  logic             dat_wr,
  input  logic             dir_wr,
  input  logic             bit_set,
  input  logic             bit_clr,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic [W-1:0]     pins,
  input  logic             pu_en_n,
  output logic [W-1:0]     lat_q,
  output logic [W-1:0]     dir_q,
  output logic             pu_on
);
  bitop_e       op;
  logic [W-1:0] rmw_byte;
  logic         pu_n_q;

  assign op = decode_bitop(bit_set, bit_clr);

  always_comb begin
    rmw_byte = pins;
    case (op)
      BITOP_SET: rmw_byte[bit_idx] = 1'b1;
      BITOP_CLR: rmw_byte[bit_idx] = 1'b0;
      default:   rmw_byte = pins;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   lat_q <= '0;
    else if (dat_wr)              lat_q <= wr_data;
    else if (op != BITOP_NONE)    lat_q <= rmw_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      dir_q <= '1;
    else if (dir_wr) dir_q <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pu_n_q <= 1'b1;
    else        pu_n_q <= pu_en_n;

  assign pu_on = ~pu_n_q;

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> dir_q == $past(wr_data)); // R2
  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> lat_q == $past(wr_data)); // R3
  AST_BITOP_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((bit_set || bit_clr) && !dat_wr) |=> lat_q[$past(bit_idx)] == $past(!bit_clr)); // R6
  AST_PU_REG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pu_on == !$past(pu_en_n)); // R7
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int W   = 8,
  parameter int LSB = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] dir_q,
  input  logic         snap_en,
  input  logic         chg_clr,
  output logic         flag
);
  localparam int HI_W = W - LSB;

  logic [HI_W-1:0] snap_q;
  logic [HI_W-1:0] diff;
  logic            mismatch;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       snap_q <= '0;
    else if (snap_en) snap_q <= pins[W-1:LSB];

  generate
    for (genvar i = 0; i < HI_W; i++) begin : g_cmp
      assign diff[i] = dir_q[LSB+i] & (pins[LSB+i] ^ snap_q[i]);
    end
  endgenerate

  assign mismatch = |diff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        flag <= 1'b0;
    else if (mismatch) flag <= 1'b1;
    else if (chg_clr)  flag <= 1'b0;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> flag); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_clr && !mismatch) |=> !flag); // R11
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_clr && flag) |=> flag); // R11
  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en |=> snap_q == $past(pins[W-1:LSB])); // R10
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(|(dir_q[W-1:LSB] & (pins[W-1:LSB] ^ snap_q)))); // R9
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
  parameter int WIDTH       = 8,
  parameter int CHG_LSB     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic                     dat_wr,
  input  logic                     dir_wr,
  input  logic                     bit_set,
  input  logic                     bit_clr,
  input  logic [$clog2(WIDTH)-1:0] bit_idx,
  input  logic                     dat_rd,
  input  logic                     rd_dir,
  output logic [WIDTH-1:0]         rd_data,
  input  logic                     pu_en_n,
  input  logic [WIDTH-1:0]         pad_in,
  output logic [WIDTH-1:0]         pad_out,
  output logic [WIDTH-1:0]         pad_oe,
  output logic [WIDTH-1:0]         pad_pu,
  output logic                     chg_flag,
  input  logic                     chg_clr
);
  localparam int IDX_W = $clog2(WIDTH);

  logic [WIDTH-1:0] pins_s;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] dir_q;
  logic             pu_on;
  logic             snap_en;

  gpio_pin_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pins_s)
  );

  gpio_port_regs #(.W(WIDTH), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .dat_wr(dat_wr),
    .dir_wr(dir_wr), .bit_set(bit_set), .bit_clr(bit_clr),
    .bit_idx(bit_idx), .pins(pins_s), .pu_en_n(pu_en_n),
    .lat_q(lat_q), .dir_q(dir_q), .pu_on(pu_on)
  );

  assign snap_en = dat_rd | dat_wr | bit_set | bit_clr;

  gpio_chg_detect #(.W(WIDTH), .LSB(CHG_LSB)) u_chg (
    .clk(clk), .rst_n(rst_n), .pins(pins_s), .dir_q(dir_q),
    .snap_en(snap_en), .chg_clr(chg_clr), .flag(chg_flag)
  );

  assign rd_data = rd_dir ? dir_q : pins_s;
  assign pad_out = lat_q;
  assign pad_oe  = ~dir_q;
  assign pad_pu  = pu_on ? dir_q : '0;

  AST_PU_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0); // R7
  AST_READ_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ##1 (rd_dir || rd_data == $past(pad_in, 2))); // R4
endmodule

// File: tb/gpio_chg_port_tb_top.sv
module gpio_chg_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int LSB        = 4;
  localparam int STAGES     = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         dat_wr = 1'b0, dir_wr = 1'b0, bit_set = 1'b0, bit_clr = 1'b0;
  logic [2:0]   bit_idx = '0;
  logic         dat_rd = 1'b0, rd_dir = 1'b0, pu_en_n = 1'b1, chg_clr = 1'b0;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] rd_data, pad_out, pad_oe, pad_pu;
  logic         chg_flag;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_chg_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .dat_wr(dat_wr),
    .dir_wr(dir_wr), .bit_set(bit_set), .bit_clr(bit_clr),
    .bit_idx(bit_idx), .dat_rd(dat_rd), .rd_dir(rd_dir),
    .rd_data(rd_data), .pu_en_n(pu_en_n), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .chg_flag(chg_flag), .chg_clr(chg_clr)
  );

  // Behavioural reference model
  logic [W-1:0] pin_q[$];
  logic [W-1:0] m_dir, m_lat, m_snap;
  logic         m_flag, m_pu;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q.delete();
      for (int k = 0; k < STAGES; k++) pin_q.push_back('0);
      m_dir = '1; m_lat = '0; m_snap = '0; m_flag = 1'b0; m_pu = 1'b0;
    end else begin
      logic [W-1:0] seen;
      logic [W-1:0] nb;
      logic         diff;
      seen = pin_q[0];
      diff = 1'b0;
      for (int k = LSB; k < W; k++)
        if (m_dir[k] && (seen[k] != m_snap[k-LSB])) diff = 1'b1;
      if (diff) m_flag = 1'b1;
      else if (chg_clr) m_flag = 1'b0;
      if (dat_rd || dat_wr || bit_set || bit_clr) m_snap = seen >> LSB;
      if (dat_wr) m_lat = wr_data;
      else if (bit_set || bit_clr) begin
        nb = seen;
        nb[bit_idx] = !bit_clr;
        m_lat = nb;
      end
      if (dir_wr) m_dir = wr_data;
      m_pu = !pu_en_n;
      void'(pin_q.pop_front());
      pin_q.push_back(pad_in);
    end
  end

  task automatic cmp(input string req, input string nm, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%02h expected=%02h at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp("R2", "pad_oe", pad_oe, ~m_dir);
    cmp("R3/R6", "pad_out", pad_out, m_lat);
    cmp("R7", "pad_pu", pad_pu, m_pu ? m_dir : '0);
    cmp("R8/R9/R10/R11", "chg_flag", {7'd0, chg_flag}, {7'd0, m_flag});
    if (rd_dir) cmp("R5", "rd_data", rd_data, m_dir);
    else        cmp("R4", "rd_data", rd_data, pin_q[0]);
  endtask

  task automatic idle();
    dat_wr = 0; dir_wr = 0; bit_set = 0; bit_clr = 0; dat_rd = 0; chg_clr = 0;
  endtask

  // One cycle: check outputs at the falling edge, then present new inputs
  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    // R1: reset values held while reset is asserted
    pu_en_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      cmp("R1", "pad_oe", pad_oe, 8'h00);
      cmp("R1", "pad_out", pad_out, 8'h00);
      cmp("R1", "pad_pu", pad_pu, 8'h00);
      cmp("R1", "chg_flag", {7'd0, chg_flag}, 8'h00);
    end
    rst_n = 1'b1;
    step();
    // R7: pull-ups on all input pins
    step(); step();
    // R2 / R3: upper nibble outputs, latch write
    wr_data = 8'h0F; dir_wr = 1; step(); idle();
    wr_data = 8'hA5; dat_wr = 1; step(); idle();
    // R9: toggling output pins and low pins never flags
    pad_in = 8'hF3; repeat (4) step();
    pad_in = 8'h0C; repeat (4) step();
    // R4 / R5: reads
    dat_rd = 1; step(); idle();
    rd_dir = 1; step(); rd_dir = 0; step();
    // R8: upper nibble becomes input, change a pin
    wr_data = 8'hF0; dir_wr = 1; step(); idle();
    step(); step();
    dat_rd = 1; step(); idle();
    chg_clr = 1; step(); idle();
    pad_in = 8'h4C; repeat (4) step();
    // R11: clear ignored while mismatch persists
    chg_clr = 1; repeat (2) step(); idle();
    // R10: read ends mismatch, then clear works
    dat_rd = 1; step(); idle();
    chg_clr = 1; step(); idle();
    repeat (3) step();
    // R6: set and clear with pin mismatch against latch, priorities
    bit_idx = 3'd1; bit_set = 1; step(); idle();
    bit_idx = 3'd6; bit_clr = 1; step(); idle();
    bit_idx = 3'd0; bit_set = 1; bit_clr = 1; step(); idle();
    wr_data = 8'h3C; dat_wr = 1; bit_idx = 3'd7; bit_set = 1; step(); idle();
    pu_en_n = 1; step(); step();
    // Pseudo-random mixed traffic
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      idle();
      if (lfsr[3:0] == 4'h1) pad_in = lfsr[15:8] ^ lfsr[7:0];
      wr_data = lfsr[11:4];
      dir_wr  = (lfsr[6:2] == 5'h07);
      dat_wr  = (lfsr[5:2] == 4'h9);
      dat_rd  = (lfsr[7:5] == 3'h2);
      bit_set = (lfsr[9:7] == 3'h5);
      bit_clr = (lfsr[12:10] == 3'h3);
      bit_idx = lfsr[14:12];
      chg_clr = lfsr[1];
      rd_dir  = lfsr[15];
      if (lfsr[8:4] == 5'h11) pu_en_n = ~pu_en_n;
      step();
    end
    idle();
    step();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule